// File: doc/BRIEF.md
# DDR3 Data-Phase Latency Scheduler

This block sits between a DDR3 command sequencer and the data path. Each cycle it takes already-decoded read and write command strobes, a per-command burst-chop flag, and the programmed latency settings. From these it produces the per-cycle timing enables for the data phase. For reads it raises a data-valid window; for writes it raises a data-capture window. In both directions it raises a strobe enable that opens one cycle early to form the preamble.

Data moves on both clock edges, so a full 8-beat burst fills four clock cycles. A chopped 4-beat burst keeps the same four-cycle slot but carries data in only its first two cycles. The read latency is the posted-CAS additive latency plus the CAS latency. The write latency is the additive latency plus the CAS write latency, or, in tied mode, one less than the read latency. Any setting outside its legal range is flagged and clamped to the nearest legal value.

Top module: `ddr_lat_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, rd_data_vld, wr_data_cap, rd_dqs_en and wr_dqs_en are all low.
- R2: A read command sampled at clock edge k drives rd_data_vld high in the four cycles that follow edges k+RL to k+RL+3, where RL = AL + CL.
- R3: With tie_wl low, a write command sampled at edge k drives wr_data_cap high in the cycles that follow edges k+WL to k+WL+3, where WL = AL + CWL.
- R4: With tie_wl high, WL = AL + CL - 1, and the cfg_cwl value has no effect on write timing.
- R5: A command issued with chop = 1 is a 4-beat burst, and its data enable is high only in the first two cycles of its four-cycle slot.
- R6: The strobe enable of each direction is high in the cycle before the first data cycle of a burst, and in every cycle in which that direction's data enable is high.
- R7: Commands of one direction spaced exactly four cycles apart give an unbroken data enable with no gap cycle.
- R8: cfg_err is high exactly when CL is outside 6..11, CWL is outside 5..8 or AL is above 10. The latency then uses the clamped values: CL to 6..11, CWL to 5..8, AL to at most 10.
- R9: A read and a write command in the same cycle are both scheduled, each on its own latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_cmd | input | 1 | Decoded read command strobe |
| wr_cmd | input | 1 | Decoded write command strobe |
| chop | input | 1 | 1 = this cycle's command is a chopped 4-beat burst |
| tie_wl | input | 1 | 1 = write latency derived as read latency minus one |
| cfg_al | input | 4 | Additive latency setting |
| cfg_cl | input | 4 | CAS latency setting |
| cfg_cwl | input | 4 | CAS write latency setting |
| rd_data_vld | output | 1 | Read data valid this cycle |
| rd_dqs_en | output | 1 | Read strobe enable (preamble and data) |
| wr_data_cap | output | 1 | Capture write data this cycle |
| wr_dqs_en | output | 1 | Write strobe window (preamble and data) |
| cfg_err | output | 1 | Latency setting out of range |

## Verification
Each read's data window is due RL edges after the edge that samples the command, and each write's window WL edges after it. Both strobe enables are due one edge earlier than their data window. The bench keeps a per-edge table of expected enables: when it drives a command it fills in the entries that command's latency and burst length predict. After every falling clock edge it compares all four registered outputs against the entry for the edge just passed. cfg_err is combinational, so it is checked one time step after each settings change, with no clock edge in between.

// File: rtl/ddr_lat_pkg.sv
package ddr_lat_pkg;

    localparam int CFG_W    = 4;
    localparam int AL_MAX_I = 10;
    localparam int CL_MAX_I = 11;
    localparam int LAT_W    = $clog2(AL_MAX_I + CL_MAX_I + 1);
    localparam int PIPE_D   = AL_MAX_I + CL_MAX_I;
    localparam int SLOT_CYC = 4;
    localparam int CHOP_CYC = 2;

    typedef logic [CFG_W-1:0] cfg_t;
    typedef logic [LAT_W-1:0] lat_t;

    localparam cfg_t AL_MIN  = cfg_t'(0);
    localparam cfg_t AL_MAX  = cfg_t'(AL_MAX_I);
    localparam cfg_t CL_MIN  = cfg_t'(6);
    localparam cfg_t CL_MAX  = cfg_t'(CL_MAX_I);
    localparam cfg_t CWL_MIN = cfg_t'(5);
    localparam cfg_t CWL_MAX = cfg_t'(8);

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    typedef struct packed {
        cfg_t al;
        cfg_t cl;
        cfg_t cwl;
        logic tie;
    } lat_cfg_t;

    typedef struct packed {
        lat_t rl;
        lat_t wl;
        logic err;
    } lat_set_t;

    function automatic cfg_t clamp_cfg(cfg_t v, cfg_t lo, cfg_t hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic out_of_range(cfg_t v, cfg_t lo, cfg_t hi);
        return (v < lo) || (v > hi);
    endfunction

endpackage

// File: rtl/ddr_lat_calc.sv
module ddr_lat_calc
    import ddr_lat_pkg::*;
(
    input  lat_cfg_t cfg,
    output lat_set_t lat
);
    cfg_t al_c, cl_c, cwl_c;
    lat_t rl_sum;

    always_comb begin
        al_c   = clamp_cfg(cfg.al,  AL_MIN,  AL_MAX);
        cl_c   = clamp_cfg(cfg.cl,  CL_MIN,  CL_MAX);
        cwl_c  = clamp_cfg(cfg.cwl, CWL_MIN, CWL_MAX);
        rl_sum = LAT_W'(al_c) + LAT_W'(cl_c);

        lat.rl  = rl_sum;
        lat.wl  = cfg.tie ? (rl_sum - LAT_W'(1))
                          : (LAT_W'(al_c) + LAT_W'(cwl_c));
        lat.err = out_of_range(cfg.al,  AL_MIN,  AL_MAX)
                | out_of_range(cfg.cl,  CL_MIN,  CL_MAX)
                | out_of_range(cfg.cwl, CWL_MIN, CWL_MAX);
    end
endmodule

// File: rtl/ddr_burst_track.sv
module ddr_burst_track
    import ddr_lat_pkg::*;
#(
    parameter int DEPTH = PIPE_D,
    parameter int SLOT  = SLOT_CYC,
    parameter int CHOPC = CHOP_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd,
    input  logic chop,
    input  lat_t lat,
    output logic data_en,
    output logic strobe_en
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(SLOT + 1);

    logic [DEPTH-1:0] mark_q, mark_d;
    logic [DEPTH-1:0] chop_q, chop_d;
    logic [CNT_W-1:0] left_q;
    logic             slot_chop_q;
    logic [IDX_W-1:0] slot_idx;

    always_comb begin
        slot_idx = IDX_W'(lat - LAT_W'(1));
        mark_d   = mark_q >> 1;
        chop_d   = chop_q >> 1;
        if (cmd && (lat != '0) && (int'(lat) <= DEPTH)) begin
            mark_d[slot_idx] = 1'b1;
            chop_d[slot_idx] = chop;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mark_q      <= '0;
            chop_q      <= '0;
            left_q      <= '0;
            slot_chop_q <= 1'b0;
        end else begin
            mark_q <= mark_d;
            chop_q <= chop_d;
            if (mark_q[0]) begin
                left_q      <= CNT_W'(SLOT);
                slot_chop_q <= chop_q[0];
            end else if (left_q != '0) begin
                left_q <= left_q - CNT_W'(1);
            end
        end
    end

    always_comb begin
        data_en   = (left_q != '0) &&
                    (!slot_chop_q || (left_q > CNT_W'(SLOT - CHOPC)));
        strobe_en = mark_q[0] | data_en;
    end
endmodule

// File: rtl/ddr_lat_sched.sv
module ddr_lat_sched
    import ddr_lat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_cmd,
    input  logic       wr_cmd,
    input  logic       chop,
    input  logic       tie_wl,
    input  logic [3:0] cfg_al,
    input  logic [3:0] cfg_cl,
    input  logic [3:0] cfg_cwl,
    output logic       rd_data_vld,
    output logic       rd_dqs_en,
    output logic       wr_data_cap,
    output logic       wr_dqs_en,
    output logic       cfg_err
);
    lat_cfg_t cfg;
    lat_set_t lat;
    logic [1:0] cmd_v;
    lat_t       lat_v [2];
    logic [1:0] data_v;
    logic [1:0] strb_v;

    always_comb begin
        cfg.al  = cfg_al;
        cfg.cl  = cfg_cl;
        cfg.cwl = cfg_cwl;
        cfg.tie = tie_wl;
    end

    ddr_lat_calc u_calc (
        .cfg (cfg),
        .lat (lat)
    );

    always_comb begin
        cmd_v[DIR_RD] = rd_cmd;
        cmd_v[DIR_WR] = wr_cmd;
        lat_v[DIR_RD] = lat.rl;
        lat_v[DIR_WR] = lat.wl;
    end

    for (genvar d = 0; d < 2; d++) begin : g_dir
        ddr_burst_track #(
            .DEPTH (PIPE_D),
            .SLOT  (SLOT_CYC),
            .CHOPC (CHOP_CYC)
        ) u_trk (
            .clk       (clk),
            .rst       (rst),
            .cmd       (cmd_v[d]),
            .chop      (chop),
            .lat       (lat_v[d]),
            .data_en   (data_v[d]),
            .strobe_en (strb_v[d])
        );
    end

    always_comb begin
        rd_data_vld = data_v[DIR_RD];
        rd_dqs_en   = strb_v[DIR_RD];
        wr_data_cap = data_v[DIR_WR];
        wr_dqs_en   = strb_v[DIR_WR];
        cfg_err     = lat.err;
    end
endmodule

// File: rtl/ddr_lat_sched_chk.sv
module ddr_lat_sched_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] cfg_al,
    input logic [3:0] cfg_cl,
    input logic [3:0] cfg_cwl,
    input logic       rd_data_vld,
    input logic       rd_dqs_en,
    input logic       wr_data_cap,
    input logic       wr_dqs_en,
    input logic       cfg_err
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_data_vld && !wr_data_cap && !rd_dqs_en && !wr_dqs_en)); // R1

    AST_RD_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data_vld) |-> $past(rd_dqs_en)); // R6

    AST_WR_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_data_cap) |-> $past(wr_dqs_en)); // R6

    AST_RD_STROBE_COVER: assert property (@(posedge clk) disable iff (rst)
        rd_data_vld |-> rd_dqs_en); // R6

    AST_WR_STROBE_COVER: assert property (@(posedge clk) disable iff (rst)
        wr_data_cap |-> wr_dqs_en); // R6

    AST_CFG_FLAG: assert property (@(posedge clk) disable iff (rst)
        cfg_err == ((cfg_cl < 4'd6) || (cfg_cl > 4'd11) || (cfg_cwl < 4'd5) ||
                    (cfg_cwl > 4'd8) || (cfg_al > 4'd10))); // R8
endmodule

bind ddr_lat_sched ddr_lat_sched_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_al      (cfg_al),
    .cfg_cl      (cfg_cl),
    .cfg_cwl     (cfg_cwl),
    .rd_data_vld (rd_data_vld),
    .rd_dqs_en   (rd_dqs_en),
    .wr_data_cap (wr_data_cap),
    .wr_dqs_en   (wr_dqs_en),
    .cfg_err     (cfg_err)
);

// File: tb/ddr_lat_sched_test.sv
`timescale 1ns/1ps
module ddr_lat_sched_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_cmd = 1'b0, wr_cmd = 1'b0, chop = 1'b0, tie_wl = 1'b0;
    logic [3:0] cfg_al = 4'd0, cfg_cl = 4'd6, cfg_cwl = 4'd5;
    logic rd_data_vld, rd_dqs_en, wr_data_cap, wr_dqs_en, cfg_err;

    int n_cmp = 0;
    int n_bad = 0;
    int edge_n = 0;
    int wd = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    bit exp_rv [256];
    bit exp_rs [256];
    bit exp_wv [256];
    bit exp_ws [256];

    always #10 clk = ~clk;

    ddr_lat_sched uut (
        .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .chop(chop),
        .tie_wl(tie_wl), .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_cwl(cfg_cwl),
        .rd_data_vld(rd_data_vld), .rd_dqs_en(rd_dqs_en),
        .wr_data_cap(wr_data_cap), .wr_dqs_en(wr_dqs_en), .cfg_err(cfg_err)
    );

    always @(posedge clk) edge_n <= edge_n + 1;

    function automatic int clampi(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int ref_rl();
        return clampi(int'(cfg_al), 0, 10) + clampi(int'(cfg_cl), 6, 11);
    endfunction

    function automatic int ref_wl();
        if (tie_wl) return ref_rl() - 1;
        return clampi(int'(cfg_al), 0, 10) + clampi(int'(cfg_cwl), 5, 8);
    endfunction

    task automatic chk(string what, bit act, bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at edge %0d: actual %0b expected %0b",
                     cur_req, what, edge_n, act, exp);
        end
    endtask

    // per-edge comparison of all registered outputs
    always @(negedge clk) begin
        if (!done) begin
            chk("rd_data_vld", rd_data_vld, exp_rv[edge_n % 256]);
            chk("rd_dqs_en",   rd_dqs_en,   exp_rs[edge_n % 256]);
            chk("wr_data_cap", wr_data_cap, exp_wv[edge_n % 256]);
            chk("wr_dqs_en",   wr_dqs_en,   exp_ws[edge_n % 256]);
            exp_rv[edge_n % 256] = 1'b0;
            exp_rs[edge_n % 256] = 1'b0;
            exp_wv[edge_n % 256] = 1'b0;
            exp_ws[edge_n % 256] = 1'b0;
        end
    end

    // called right after a falling edge; the command is sampled at edge_n+1
    task automatic issue(bit rd, bit wr, bit bc);
        int k = edge_n + 1;
        int nd = bc ? 2 : 4;
        rd_cmd = rd;
        wr_cmd = wr;
        chop   = bc;
        if (rd) begin
            int l = ref_rl();
            exp_rs[(k + l - 1) % 256] = 1'b1;
            for (int i = 0; i < nd; i++) begin
                exp_rv[(k + l + i) % 256] = 1'b1;
                exp_rs[(k + l + i) % 256] = 1'b1;
            end
        end
        if (wr) begin
            int l = ref_wl();
            exp_ws[(k + l - 1) % 256] = 1'b1;
            for (int i = 0; i < nd; i++) begin
                exp_wv[(k + l + i) % 256] = 1'b1;
                exp_ws[(k + l + i) % 256] = 1'b1;
            end
        end
        @(negedge clk);
        rd_cmd = 1'b0;
        wr_cmd = 1'b0;
        chop   = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(int al, int cl, int cwl, bit tie, bit exp_err);
        cfg_al  = 4'(al);
        cfg_cl  = 4'(cl);
        cfg_cwl = 4'(cwl);
        tie_wl  = tie;
        #1;
        chk("cfg_err", cfg_err, exp_err);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset holds everything low
        cur_req = "R1";
        idle(4);
        rst = 1'b0;
        idle(2);

        cur_req = "R2";
        set_cfg(0, 6, 5, 0, 0);
        issue(1, 0, 0); idle(14);
        set_cfg(3, 9, 5, 0, 0);
        issue(1, 0, 0); idle(20);

        cur_req = "R3";
        set_cfg(1, 7, 7, 0, 0);
        issue(0, 1, 0); idle(16);

        // R4: tied write latency, CWL setting must not matter
        cur_req = "R4";
        set_cfg(2, 8, 5, 1, 0);
        issue(0, 1, 0); idle(16);
        set_cfg(2, 8, 8, 1, 0);
        issue(0, 1, 0); idle(16);

        cur_req = "R5";
        set_cfg(0, 7, 6, 0, 0);
        issue(1, 0, 1); idle(14);
        issue(0, 1, 1); idle(14);

        cur_req = "R6";
        set_cfg(1, 10, 8, 0, 0);
        issue(1, 0, 0); idle(3);
        issue(1, 0, 1); idle(20);

        // R7: seamless back-to-back bursts four cycles apart
        cur_req = "R7";
        set_cfg(0, 6, 5, 0, 0);
        issue(1, 0, 0); idle(3);
        issue(1, 0, 0); idle(3);
        issue(1, 0, 0); idle(14);
        issue(0, 1, 0); idle(3);
        issue(0, 1, 0); idle(14);

        cur_req = "R9";
        set_cfg(2, 9, 6, 0, 0);
        issue(1, 1, 0); idle(18);

        // R8: out-of-range settings flagged and clamped
        cur_req = "R8";
        set_cfg(0, 3, 5, 0, 1);
        issue(1, 0, 0); idle(14);
        set_cfg(0, 14, 2, 0, 1);
        issue(1, 1, 0); idle(18);
        set_cfg(13, 6, 12, 0, 1);
        issue(1, 1, 0); idle(24);
        set_cfg(10, 11, 8, 0, 0);
        issue(1, 0, 0); idle(26);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule